// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Modes

A synchronous memory with two fully independent ports. Each port has its own clock, an enable, a write enable, a synchronous output reset, an address, a data word with separate parity bits going in, and a registered data word with parity bits coming out. Parity bits are stored and returned beside the data. They are never generated or checked.

Each port has a write mode, fixed by a parameter. The mode sets what that port's output register shows on the cycle it writes: the new word, the word the location held before the write, or its previous value. When one port writes an address that the other port reads in the same cycle, the reader gets a defined result. That result is the old contents if the writer is in read-old mode. Otherwise it is a poison word set by a parameter. A global init input loads both output registers with their initial values and blocks every other operation while it is high.

Storage is two banks, one written by each port. A word is read back as the XOR of the two banks, so neither bank has two drivers. Both ports are meant to run from clocks with a common edge. The collision decode compares the peer's inputs at this port's edge.

Top module: `dual_port_wmode_ram`

## Requirements
- R1: While a port's enable is low, its data and parity outputs keep their values and its write request leaves memory unchanged. Its output reset is ignored.
- R2: With enable high, write enable low and reset low, the word at the address appears on the outputs after the next clock edge.
- R3: A port in write-through mode (mode code 0) stores the input data and parity on an enabled write, and shows the same data and parity on its outputs after that edge.
- R4: A port in read-old mode (mode code 1) stores the new word on an enabled write, and shows the contents the location held before the write.
- R5: A port in hold mode (mode code 2) stores the new word on an enabled write, and its outputs do not change.
- R6: If one port writes and the other reads the same address on the same edge, the reader shows the POISON word when the writer is in mode 0 or 2. It shows the old contents when the writer is in mode 1. If both ports write the same address, the stored result is undefined.
- R7: An enabled edge with the output reset high loads the reset word (SRST_A or SRST_B) into that port's outputs. A write requested in the same cycle still updates memory.
- R8: Parity bits are stored and returned unchanged alongside the data word. In every word-valued parameter the parity bits occupy the bits above the data bits.
- R9: While the global init is high, each port's outputs load INIT_A or INIT_B on its clock edge, whatever the enable, reset or write inputs. No write reaches memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| srst_a | input | 1 | Port A synchronous output reset |
| addr_a | input | AW | Port A address |
| wdat_a | input | DW | Port A write data |
| wpar_a | input | PW | Port A write parity |
| rdat_a | output | DW | Port A read data |
| rpar_a | output | PW | Port A read parity |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| srst_b | input | 1 | Port B synchronous output reset |
| addr_b | input | AW | Port B address |
| wdat_b | input | DW | Port B write data |
| wpar_b | input | PW | Port B write parity |
| rdat_b | output | DW | Port B read data |
| rpar_b | output | PW | Port B read parity |
| glob_init | input | 1 | Global output initialisation |

## Verification
The functions that can fall in the same cycle are a write on one port and a read of the same address on the other port. The bench provokes this by driving both ports on one shared edge to one address, with writers in each of the three modes. It judges the reader's output against either the poison word or the old contents it recorded in the step before. It also overlaps global init with an output reset and a write request on the same edge. It then reads the address back to confirm that init won on the outputs and that no write reached memory. A write from both ports to one address is flagged and left unchecked.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic [1:0] {
    WM_THRU = 2'd0,
    WM_OLD  = 2'd1,
    WM_HOLD = 2'd2
  } wmode_e;

  // a writer in this mode leaves the peer reader with a poison word
  function automatic logic poisons_peer(wmode_e m);
    return (m != WM_OLD);
  endfunction

  // addresses match and the peer really writes
  function automatic logic peer_hit(logic peer_en, logic peer_we,
                                    logic blocked, logic same);
    return peer_en && peer_we && !blocked && same;
  endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int WW    = 9,
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wword,
  input  logic [AW-1:0] raddr0,
  input  logic [AW-1:0] raddr1,
  output logic [WW-1:0] rword0,
  output logic [WW-1:0] rword1
);

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword0 = mem[raddr0];
  assign rword1 = mem[raddr1];

endmodule

// File: rtl/dpram_out_reg.sv
module dpram_out_reg
  import dpram_pkg::*;
#(
  parameter int            WW       = 9,
  parameter wmode_e        MODE     = WM_THRU,
  parameter logic [WW-1:0] SRST_VAL = '0,
  parameter logic [WW-1:0] INIT_VAL = '0,
  parameter logic [WW-1:0] POISON   = '1
) (
  input  logic          clk,
  input  logic          init,
  input  logic          en,
  input  logic          we,
  input  logic          srst,
  input  logic [WW-1:0] wword,
  input  logic [WW-1:0] rword,
  input  logic          coll,
  output logic [WW-1:0] q
);

  // named events for the checks below
  logic ev_init, ev_off, ev_srst, ev_write, ev_read;
  logic primed;

  assign ev_init  = init;
  assign ev_off   = !init && !en;
  assign ev_srst  = !init && en && srst;
  assign ev_write = !init && en && !srst && we;
  assign ev_read  = !init && en && !srst && !we;

  always_ff @(posedge clk) begin
    if (init) primed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (ev_init) begin
      q <= INIT_VAL;
    end else if (ev_srst) begin
      q <= SRST_VAL;
    end else if (ev_write) begin
      case (MODE)
        WM_THRU: q <= wword;
        WM_OLD:  q <= rword;
        default: q <= q;
      endcase
    end else if (ev_read) begin
      q <= coll ? POISON : rword;
    end
  end

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!primed)
    ev_off |=> q === $past(q)); // R1
  AST_READ_PATH: assert property (@(posedge clk) disable iff (!primed)
    (ev_read && !coll) |=> q === $past(rword)); // R2
  AST_WRITE_THRU: assert property (@(posedge clk) disable iff (!primed)
    (ev_write && MODE == WM_THRU) |=> q === $past(wword)); // R3
  AST_WRITE_OLD: assert property (@(posedge clk) disable iff (!primed)
    (ev_write && MODE == WM_OLD) |=> q === $past(rword)); // R4
  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!primed)
    (ev_write && MODE == WM_HOLD) |=> q === $past(q)); // R5
  AST_COLL_POISON: assert property (@(posedge clk) disable iff (!primed)
    (ev_read && coll) |=> q == POISON); // R6
  AST_SRST_LOAD: assert property (@(posedge clk) disable iff (!primed)
    ev_srst |=> q == SRST_VAL); // R7
  AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!primed)
    ev_init |=> q == INIT_VAL); // R9

endmodule

// File: rtl/dual_port_wmode_ram.sv
module dual_port_wmode_ram
  import dpram_pkg::*;
#(
  parameter int                DW     = 8,
  parameter int                PW     = 1,
  parameter int                DEPTH  = 512,
  parameter wmode_e            MODE_A = WM_THRU,
  parameter wmode_e            MODE_B = WM_THRU,
  parameter logic [DW+PW-1:0]  SRST_A = '0,
  parameter logic [DW+PW-1:0]  SRST_B = '0,
  parameter logic [DW+PW-1:0]  INIT_A = '0,
  parameter logic [DW+PW-1:0]  INIT_B = '0,
  parameter logic [DW+PW-1:0]  POISON = '1,
  localparam int               AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int               WW     = DW + PW
) (
  input  logic          clk_a,
  input  logic          en_a,
  input  logic          we_a,
  input  logic          srst_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] wdat_a,
  input  logic [PW-1:0] wpar_a,
  output logic [DW-1:0] rdat_a,
  output logic [PW-1:0] rpar_a,
  input  logic          clk_b,
  input  logic          en_b,
  input  logic          we_b,
  input  logic          srst_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] wdat_b,
  input  logic [PW-1:0] wpar_b,
  output logic [DW-1:0] rdat_b,
  output logic [PW-1:0] rpar_b,
  input  logic          glob_init
);

  localparam wmode_e        MODE_V [2] = '{MODE_A, MODE_B};
  localparam logic [WW-1:0] SRST_V [2] = '{SRST_A, SRST_B};
  localparam logic [WW-1:0] INIT_V [2] = '{INIT_A, INIT_B};

  // per-port views, index 0 = A, 1 = B
  logic          clk_v  [2];
  logic          en_v   [2];
  logic          we_v   [2];
  logic          srst_v [2];
  logic [AW-1:0] addr_v [2];
  logic [WW-1:0] word_v [2];
  logic [WW-1:0] q_v    [2];

  // bank_rd[bank][port]: bank content at that port's address
  logic [WW-1:0] bank_rd [2][2];
  logic [WW-1:0] stored  [2];
  logic [WW-1:0] bank_wd [2];
  logic          bank_we [2];
  logic          coll    [2];

  assign clk_v[0]  = clk_a;   assign clk_v[1]  = clk_b;
  assign en_v[0]   = en_a;    assign en_v[1]   = en_b;
  assign we_v[0]   = we_a;    assign we_v[1]   = we_b;
  assign srst_v[0] = srst_a;  assign srst_v[1] = srst_b;
  assign addr_v[0] = addr_a;  assign addr_v[1] = addr_b;
  assign word_v[0] = {wpar_a, wdat_a};
  assign word_v[1] = {wpar_b, wdat_b};

  assign {rpar_a, rdat_a} = q_v[0];
  assign {rpar_b, rdat_b} = q_v[1];

  for (genvar p = 0; p < 2; p++) begin : g_port
    localparam int Q = 1 - p;

    // a word is the XOR of both banks; a port writes its own bank only
    assign stored[p]  = bank_rd[0][p] ^ bank_rd[1][p];
    assign bank_we[p] = en_v[p] && we_v[p] && !glob_init;
    assign bank_wd[p] = word_v[p] ^ bank_rd[Q][p];
    assign coll[p]    = peer_hit(en_v[Q], we_v[Q], glob_init,
                                 addr_v[Q] == addr_v[p])
                        && poisons_peer(MODE_V[Q]);

    dpram_bank #(
      .WW    (WW),
      .DEPTH (DEPTH),
      .AW    (AW)
    ) u_bank (
      .clk    (clk_v[p]),
      .we     (bank_we[p]),
      .waddr  (addr_v[p]),
      .wword  (bank_wd[p]),
      .raddr0 (addr_v[0]),
      .raddr1 (addr_v[1]),
      .rword0 (bank_rd[p][0]),
      .rword1 (bank_rd[p][1])
    );

    dpram_out_reg #(
      .WW       (WW),
      .MODE     (MODE_V[p]),
      .SRST_VAL (SRST_V[p]),
      .INIT_VAL (INIT_V[p]),
      .POISON   (POISON)
    ) u_out (
      .clk   (clk_v[p]),
      .init  (glob_init),
      .en    (en_v[p]),
      .we    (we_v[p]),
      .srst  (srst_v[p]),
      .wword (word_v[p]),
      .rword (stored[p]),
      .coll  (coll[p]),
      .q     (q_v[p])
    );

    // a disabled port never changes its bank
    AST_OFF_NO_WRITE: assert property (@(posedge clk_v[p])
      !en_v[p] |-> !bank_we[p]); // R1
  end

endmodule

// File: tb/test_dual_port_wmode_ram.sv
module test_dual_port_wmode_ram;
  import dpram_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] IA = 9'h0C3, IB = 9'h13C;
  localparam logic [8:0] SA = 9'h055, SB = 9'h1AA, PZ = 9'h1EE;

  // {en, we, srst, addr[9], data[8], par, exp_thru[9], exp_hold[9]}
  localparam int NV = 11;
  localparam logic [38:0] TBL [NV] = '{
    {3'b110, 9'd5, 8'h3C, 1'b1, 9'h13C, 9'h0C3}, // R3 R5 R8 write
    {3'b110, 9'd6, 8'hA5, 1'b0, 9'h0A5, 9'h0C3}, // R3 R5
    {3'b100, 9'd5, 8'h00, 1'b0, 9'h13C, 9'h13C}, // R2 R8 read
    {3'b010, 9'd5, 8'h00, 1'b0, 9'h13C, 9'h13C}, // R1 disabled write
    {3'b100, 9'd5, 8'h00, 1'b0, 9'h13C, 9'h13C}, // R1 memory kept
    {3'b100, 9'd6, 8'h00, 1'b0, 9'h0A5, 9'h0A5}, // R2
    {3'b111, 9'd7, 8'h77, 1'b1, 9'h055, 9'h055}, // R7 reset + write
    {3'b100, 9'd7, 8'h00, 1'b0, 9'h177, 9'h177}, // R7 write landed
    {3'b001, 9'd7, 8'h00, 1'b0, 9'h177, 9'h177}, // R1 reset ignored
    {3'b110, 9'd5, 8'h11, 1'b0, 9'h011, 9'h177}, // R3 R5
    {3'b100, 9'd5, 8'h00, 1'b0, 9'h011, 9'h011}  // R2
  };

  logic clk = 1'b0;
  logic glob_init;
  logic en_a, we_a, srst_a, en_b, we_b, srst_b;
  logic [8:0] addr_a, addr_b;
  logic [7:0] wdat_a, wdat_b;
  logic [0:0] wpar_a, wpar_b;
  logic [7:0] d1a, d1b, d2a, d2b;
  logic [0:0] p1a, p1b, p2a, p2b;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_port_wmode_ram #(
    .MODE_A(WM_THRU), .MODE_B(WM_OLD), .SRST_A(SA), .SRST_B(SB),
    .INIT_A(IA), .INIT_B(IB), .POISON(PZ)
  ) i_dual_port_wmode_ram (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a),
    .wdat_a(wdat_a), .wpar_a(wpar_a), .rdat_a(d1a), .rpar_a(p1a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .srst_b(srst_b), .addr_b(addr_b),
    .wdat_b(wdat_b), .wpar_b(wpar_b), .rdat_b(d1b), .rpar_b(p1b),
    .glob_init(glob_init)
  );

  dual_port_wmode_ram #(
    .MODE_A(WM_HOLD), .MODE_B(WM_OLD), .SRST_A(SA), .SRST_B(SB),
    .INIT_A(IA), .INIT_B(IB), .POISON(PZ)
  ) i_dual_port_wmode_ram_hold (
    .clk_a(clk), .en_a(en_a), .we_a(we_a), .srst_a(srst_a), .addr_a(addr_a),
    .wdat_a(wdat_a), .wpar_a(wpar_a), .rdat_a(d2a), .rpar_a(p2a),
    .clk_b(clk), .en_b(en_b), .we_b(we_b), .srst_b(srst_b), .addr_b(addr_b),
    .wdat_b(wdat_b), .wpar_b(wpar_b), .rdat_b(d2b), .rpar_b(p2b),
    .glob_init(glob_init)
  );

  task automatic check(string what, logic [8:0] act, logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic port_a(logic e, logic w, logic s, logic [8:0] ad,
                        logic [7:0] d, logic p);
    en_a = e; we_a = w; srst_a = s; addr_a = ad; wdat_a = d; wpar_a = p;
  endtask

  task automatic port_b(logic e, logic w, logic s, logic [8:0] ad,
                        logic [7:0] d, logic p);
    en_b = e; we_b = w; srst_b = s; addr_b = ad; wdat_b = d; wpar_b = p;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    glob_init = 1'b1;
    port_a(0, 0, 0, 0, 0, 0);
    port_b(0, 0, 0, 0, 0, 0);
    cyc(); cyc();
    glob_init = 1'b0;
    check("R9 init A thru",  {p1a, d1a}, IA);
    check("R9 init A hold",  {p2a, d2a}, IA);
    check("R9 init B",       {p1b, d1b}, IB);

    for (int i = 0; i < NV; i++) begin
      port_a(TBL[i][38], TBL[i][37], TBL[i][36], TBL[i][35:27],
             TBL[i][26:19], TBL[i][18]);
      cyc();
      check($sformatf("R1-table step %0d thru", i), {p1a, d1a}, TBL[i][17:9]);
      check($sformatf("R1-table step %0d hold", i), {p2a, d2a}, TBL[i][8:0]);
    end
    port_a(0, 0, 0, 0, 0, 0);

    // R4 read-old on port B
    port_b(1, 1, 0, 9'd5, 8'h99, 1'b1);
    cyc();
    check("R4 old word B i1", {p1b, d1b}, 9'h011);
    check("R4 old word B i2", {p2b, d2b}, 9'h011);
    port_b(1, 0, 0, 9'd5, 0, 0);
    cyc();
    check("R4 stored B", {p1b, d1b}, 9'h199);

    // R6 collision: A writes (thru / hold), B reads same address
    port_a(1, 1, 0, 9'd8, 8'h22, 1'b0);
    port_b(1, 0, 0, 9'd8, 0, 0);
    cyc();
    check("R6 thru writer A", {p1a, d1a}, 9'h022);
    check("R6 hold writer A", {p2a, d2a}, 9'h011);
    check("R6 poison B thru", {p1b, d1b}, PZ);
    check("R6 poison B hold", {p2b, d2b}, PZ);

    // R6 collision: B writes in read-old mode, A reads old contents
    port_a(1, 0, 0, 9'd5, 0, 0);
    port_b(1, 1, 0, 9'd5, 8'h44, 1'b0);
    cyc();
    check("R6 old to A i1", {p1a, d1a}, 9'h199);
    check("R6 old to A i2", {p2a, d2a}, 9'h199);
    check("R6 old on B",    {p1b, d1b}, 9'h199);
    port_b(1, 0, 0, 9'd8, 0, 0);
    cyc();
    check("R6 new word A",  {p1a, d1a}, 9'h044);
    check("R6 hold wrote",  {p2b, d2b}, 9'h022);

    // R6 dual write to one address: flagged, not checked
    port_a(1, 1, 0, 9'd10, 8'h12, 1'b0);
    port_b(1, 1, 0, 9'd10, 8'h34, 1'b1);
    cyc();
    $display("note: R6 dual write to one address, result not checked");

    // R9 init beats reset and write
    glob_init = 1'b1;
    port_a(1, 1, 1, 9'd5, 8'h6E, 1'b1);
    port_b(1, 0, 0, 9'd8, 0, 0);
    cyc();
    check("R9 init over srst A", {p1a, d1a}, IA);
    check("R9 init over read B", {p1b, d1b}, IB);
    glob_init = 1'b0;
    port_a(1, 0, 0, 9'd5, 0, 0);
    port_b(0, 0, 0, 9'd8, 0, 0);
    cyc();
    check("R9 write blocked", {p1a, d1a}, 9'h044);
    check("R1 B held",        {p1b, d1b}, IB);

    // R8 parity alone differs
    port_a(1, 1, 0, 9'd12, 8'h44, 1'b1);
    cyc();
    port_a(1, 0, 0, 9'd12, 0, 0);
    cyc();
    check("R8 parity kept", {p2a, d2a}, 9'h144);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule